// File: doc/BRIEF.md
# Serial Clock Select and Bit Counter

This block is the clocking core of a small serial shifter. A narrow event counter advances once for every clock event from a source that software picks: a software strobe, a pulse from a timer compare match, or a rising or falling edge on the external serial clock pin. The pin passes through a synchronizer and an edge detector. In the two external modes, a software write can stand in for a pin edge, which lets firmware step the counter without driving the pin.

Each count event also shifts the serial data input into a small data register. The most significant bit of that register drives the serial data output. A wire-mode field controls only the output-enable signals. Counting and sampling go on unchanged even while every output is off. When the counter wraps, an overflow flag is set. An external start detector can set a start flag. Each flag raises its interrupt request whenever its enable bit is also set.

Software uses a simple register port with four addresses:
- Address 0 is control.
- Address 1 is status.
- Address 2 is the data register.
- Address 3 is the counter.

Top module: `scu_clk_counter`

## Requirements
- R1: After reset the control register, the counter, the data register, both flags, both interrupt requests and both output enables are 0.
- R2: Control bits 3:2 select the counter clock: 00 software strobe, 01 timer match, 10 pin rising edge, 11 pin falling edge. Events from a source that is not selected leave the counter unchanged.
- R3: With clock select 00, a control write (address 0) whose bit 1 is 1 advances the counter by exactly one. A write with only bit 0 set does not advance it.
- R4: With clock select 01, each single-cycle `tmr_match` pulse advances the counter by one.
- R5: With clock select 10 (or 11), each rising (or falling) change of `sclk_pin` advances the counter by exactly one. The new value is visible within four clock cycles of the pin change. The opposite edge does not count.
- R6: With clock select 10 or 11, a control write that sets both bit 1 and bit 0 advances the counter by one. A write that sets bit 0 alone does not.
- R7: When the counter wraps from all ones to 0, the overflow flag (status bit 6) is set. Writing 1 to status bit 6 clears it.
- R8: `ovf_irq` equals control bit 6 AND the overflow flag. `start_irq` equals control bit 7 AND the start flag. Setting an enable while its flag is pending raises the request right after that write. A `start_hit` pulse sets the start flag (status bit 7), and writing 1 to status bit 7 clears it.
- R9: Control bits 5:4 set the wire mode: 00 leaves both enables low, 01 drives `dout_oe` only, 10 and 11 drive both `dout_oe` and `sclk_oe`. Counting is unaffected by the mode.
- R10: Control bits 7:2 read back as written. Bits 1:0 are strobes that read back as 0.
- R11: Each count event shifts `sdi` into bit 0 of the data register (address 2, read/write). `sdo` shows its top bit.
- R12: A write to address 3 loads the counter. Reading address 3, or status bits 3:0, returns the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sclk_pin | input | 1 | External serial clock pin, asynchronous |
| tmr_match | input | 1 | Timer compare-match pulse |
| sdi | input | 1 | Serial data input |
| start_hit | input | 1 | Pulse from an external start detector |
| count | output | CNT_W | Counter value |
| sdo | output | 1 | Top bit of the data register |
| ovf_irq | output | 1 | Overflow interrupt request |
| start_irq | output | 1 | Start interrupt request |
| dout_oe | output | 1 | Data output enable |
| sclk_oe | output | 1 | Clock output enable |

## Verification
The assertions check on every cycle that:
- the counter only ever steps by one or takes a loaded value, and holds when no write, timer pulse or pin edge occurred;
- each synchronized pin edge lasts a single cycle;
- a wrap always sets the overflow flag;
- an enabled pending flag always raises its request;
- wire mode 00 keeps both enables low.

Only the bench scenarios can show behaviours that depend on the source encoding and on what software reads:
- which source counts in each clock-select mode;
- that a software strobe substitutes for the pin in the external modes;
- write-one-to-clear behaviour of the flags;
- strobe bits reading back as 0;
- the bit order of the data register.

// File: rtl/scu_pkg.sv
package scu_pkg;
   typedef enum logic [1:0] {
      CS_SOFT  = 2'b00,
      CS_TIMER = 2'b01,
      CS_RISE  = 2'b10,
      CS_FALL  = 2'b11
   } clk_sel_e;

   typedef enum logic [1:0] {
      WM_OFF   = 2'b00,
      WM_DATA  = 2'b01,
      WM_BOTH  = 2'b10,
      WM_BOTH2 = 2'b11
   } wire_mode_e;

   typedef struct packed {
      logic       start_ie;
      logic       ovf_ie;
      wire_mode_e wmode;
      clk_sel_e   csel;
   } ctrl_t;

   localparam int BUS_W = 8;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;
   localparam logic [1:0] A_CNT  = 2'd3;
   localparam int BIT_START = 7;
   localparam int BIT_OVF   = 6;
   localparam int BIT_CKSTB = 1;
   localparam int BIT_TGSTB = 0;
endpackage

// File: rtl/scu_pin_sync.sv
module scu_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scu_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
   assign fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/scu_count_src.sv
module scu_count_src
   import scu_pkg::*;
(
   input  clk_sel_e csel_q,
   input  logic     ctrl_wr,
   input  clk_sel_e csel_wr,
   input  logic     ck_strobe,
   input  logic     tg_strobe,
   input  logic     tmr_match,
   input  logic     pin_rise,
   input  logic     pin_fall,
   output logic     step
);
   logic sw_step;
   logic hw_step;

   always_comb begin
      sw_step = 1'b0;
      if (ctrl_wr && ck_strobe) begin
         if (csel_wr == CS_SOFT)   sw_step = 1'b1;
         else if (csel_wr[1])      sw_step = tg_strobe;
         else                      sw_step = 1'b0;
      end
   end

   always_comb begin
      unique case (csel_q)
         CS_TIMER: hw_step = tmr_match;
         CS_RISE:  hw_step = pin_rise;
         CS_FALL:  hw_step = pin_fall;
         default:  hw_step = 1'b0;
      endcase
   end

   assign step = sw_step | hw_step;
endmodule

// File: rtl/scu_counter.sv
module scu_counter #(
   parameter int CNT_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              ovf_clr,
   input  logic              sdi,
   input  logic              sr_load,
   input  logic [DATA_W-1:0] sr_val,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_flag,
   output logic [DATA_W-1:0] sr_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic wrap;
   assign wrap = step && !cnt_load && (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (cnt_load) count <= cnt_val;
      else if (step)     count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (wrap)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (sr_load) sr_q <= sr_val;
      else if (step)    sr_q <= {sr_q[DATA_W-2:0], sdi};
   end
endmodule

// File: rtl/scu_out_en.sv
module scu_out_en
   import scu_pkg::*;
(
   input  wire_mode_e wmode,
   output logic       dout_oe,
   output logic       sclk_oe
);
   always_comb begin
      unique case (wmode)
         WM_OFF:  begin dout_oe = 1'b0; sclk_oe = 1'b0; end
         WM_DATA: begin dout_oe = 1'b1; sclk_oe = 1'b0; end
         default: begin dout_oe = 1'b1; sclk_oe = 1'b1; end
      endcase
   end
endmodule

// File: rtl/scu_clk_counter.sv
module scu_clk_counter
   import scu_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [1:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             sclk_pin,
   input  logic             tmr_match,
   input  logic             sdi,
   input  logic             start_hit,
   output logic [CNT_W-1:0] count,
   output logic             sdo,
   output logic             ovf_irq,
   output logic             start_irq,
   output logic             dout_oe,
   output logic             sclk_oe
);
   generate
      if (CNT_W < 1 || CNT_W > 6) begin : g_bad_cnt
         $error("scu_clk_counter: CNT_W must be 1..6");
      end
      if (DATA_W < 2 || DATA_W > BUS_W) begin : g_bad_data
         $error("scu_clk_counter: DATA_W must be 2..8");
      end
   endgenerate

   localparam int STAT_PAD = BUS_W - 2 - CNT_W;
   localparam int DATA_PAD = BUS_W - DATA_W;
   localparam int CNT_PAD  = BUS_W - CNT_W;

   ctrl_t             ctrl_q;
   ctrl_t             ctrl_wr_val;
   logic              ctrl_wr;
   logic              stat_wr;
   logic              data_wr;
   logic              cnt_wr;
   logic              start_flag;
   logic              ovf_flag;
   logic              pin_rise;
   logic              pin_fall;
   logic              cnt_step;
   logic [DATA_W-1:0] sr_q;

   assign ctrl_wr     = bus_we && (bus_addr == A_CTRL);
   assign stat_wr     = bus_we && (bus_addr == A_STAT);
   assign data_wr     = bus_we && (bus_addr == A_DATA);
   assign cnt_wr      = bus_we && (bus_addr == A_CNT);
   assign ctrl_wr_val = ctrl_t'(bus_wdata[7:2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_wr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            start_flag <= 1'b0;
      else if (start_hit)                    start_flag <= 1'b1;
      else if (stat_wr && bus_wdata[BIT_START]) start_flag <= 1'b0;
   end

   scu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (sclk_pin),
      .rise  (pin_rise),
      .fall  (pin_fall)
   );

   scu_count_src u_src (
      .csel_q    (ctrl_q.csel),
      .ctrl_wr   (ctrl_wr),
      .csel_wr   (ctrl_wr_val.csel),
      .ck_strobe (bus_wdata[BIT_CKSTB]),
      .tg_strobe (bus_wdata[BIT_TGSTB]),
      .tmr_match (tmr_match),
      .pin_rise  (pin_rise),
      .pin_fall  (pin_fall),
      .step      (cnt_step)
   );

   scu_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (cnt_step),
      .cnt_load (cnt_wr),
      .cnt_val  (bus_wdata[CNT_W-1:0]),
      .ovf_clr  (stat_wr && bus_wdata[BIT_OVF]),
      .sdi      (sdi),
      .sr_load  (data_wr),
      .sr_val   (bus_wdata[DATA_W-1:0]),
      .count    (count),
      .ovf_flag (ovf_flag),
      .sr_q     (sr_q)
   );

   scu_out_en u_oe (
      .wmode   (ctrl_q.wmode),
      .dout_oe (dout_oe),
      .sclk_oe (sclk_oe)
   );

   assign sdo       = sr_q[DATA_W-1];
   assign ovf_irq   = ctrl_q.ovf_ie & ovf_flag;
   assign start_irq = ctrl_q.start_ie & start_flag;

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = {ctrl_q, 2'b00};
         A_STAT:  bus_rdata = {start_flag, ovf_flag, {STAT_PAD{1'b0}}, count};
         A_DATA:  bus_rdata = {{DATA_PAD{1'b0}}, sr_q};
         default: bus_rdata = {{CNT_PAD{1'b0}}, count};
      endcase
   end
endmodule

// File: rtl/scu_clk_counter_chk.sv
module scu_clk_counter_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic             tmr_match,
   input logic             pin_rise,
   input logic             pin_fall,
   input logic             cnt_load,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             start_flag,
   input logic             ovf_ie,
   input logic             start_ie,
   input logic [1:0]       wmode,
   input logic             ovf_irq,
   input logic             start_irq,
   input logic             dout_oe,
   input logic             sclk_oe
);
   // R1 / R12: the counter moves only by one step or by a load
   a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      ((count != $past(count)) && !$past(cnt_load)) |-> (count == $past(count) + 1'b1));

   // R2: with no write, timer pulse or pin edge the counter holds
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!bus_we && !tmr_match && !pin_rise && !pin_fall) |-> $stable(count));

   // R5: a pin edge lasts one cycle
   a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise |=> !pin_rise);
   a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      pin_fall |=> !pin_fall);

   // R7: a wrap always leaves the overflow flag set
   a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(count) == {CNT_W{1'b1}} && count == '0 && !$past(cnt_load)) |-> ovf_flag);

   // R8: an enabled pending flag raises its request
   a_r8_ovf_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && ovf_ie) |-> ovf_irq);
   a_r8_start_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (start_flag && start_ie) |-> start_irq);

   // R9: wire mode 00 disables both drivers; clock drive implies data drive
   a_r9_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wmode == 2'b00) |-> (!dout_oe && !sclk_oe));
   a_r9_clk_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_oe |-> dout_oe);
endmodule

bind scu_clk_counter scu_clk_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .tmr_match  (tmr_match),
   .pin_rise   (pin_rise),
   .pin_fall   (pin_fall),
   .cnt_load   (cnt_wr),
   .count      (count),
   .ovf_flag   (ovf_flag),
   .start_flag (start_flag),
   .ovf_ie     (ctrl_q.ovf_ie),
   .start_ie   (ctrl_q.start_ie),
   .wmode      (ctrl_q.wmode),
   .ovf_irq    (ovf_irq),
   .start_irq  (start_irq),
   .dout_oe    (dout_oe),
   .sclk_oe    (sclk_oe)
);

// File: tb/scu_clk_counter_test.sv
module scu_clk_counter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       sclk_pin = 1'b0;
   logic       tmr_match = 1'b0;
   logic       sdi = 1'b0;
   logic       start_hit = 1'b0;
   logic [3:0] count;
   logic       sdo, ovf_irq, start_irq, dout_oe, sclk_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scu_clk_counter uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_pin(sclk_pin),
      .tmr_match(tmr_match), .sdi(sdi), .start_hit(start_hit), .count(count),
      .sdo(sdo), .ovf_irq(ovf_irq), .start_irq(start_irq),
      .dout_oe(dout_oe), .sclk_oe(sclk_oe)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 8'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse_tmr();
      @(negedge clk); tmr_match = 1'b1;
      @(negedge clk); tmr_match = 1'b0;
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk); sclk_pin = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
      rd(2'd1, d); chk("R1 status", d, 8'h00);
      rd(2'd2, d); chk("R1 data", d, 8'h00);
      chk("R1 outputs", {count, ovf_irq, start_irq, dout_oe, sclk_oe}, 0);
   endtask

   task automatic t_soft();
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h02); chk("R3 soft strobe", count, 1);
      wr(2'd0, 8'h01); chk("R3 toggle alone", count, 1);
      pulse_tmr();     chk("R2 timer ignored in soft", count, 1);
      set_pin(1'b1);   chk("R2 pin ignored in soft", count, 1);
      set_pin(1'b0);
   endtask

   task automatic t_timer();
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h04);
      repeat (3) pulse_tmr();
      chk("R4 timer count", count, 3);
      wr(2'd0, 8'h06); chk("R2 soft strobe ignored in timer", count, 3);
   endtask

   task automatic t_pin();
      logic [7:0] d;
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h08);
      set_pin(1'b1); chk("R5 rise counted (R9 outputs off)", count, 1);
      chk("R9 oe off while counting", {dout_oe, sclk_oe}, 0);
      set_pin(1'b0); chk("R5 fall ignored in rise mode", count, 1);
      pulse_tmr();   chk("R2 timer ignored in rise mode", count, 1);
      wr(2'd0, 8'h0C);
      set_pin(1'b1); chk("R5 rise ignored in fall mode", count, 1);
      set_pin(1'b0); chk("R5 fall counted", count, 2);
      wr(2'd0, 8'h0B); chk("R6 external strobe", count, 3);
      wr(2'd0, 8'h09); chk("R6 toggle without clock strobe", count, 3);
      rd(2'd0, d);     chk("R10 strobes read 0", d, 8'h08);
   endtask

   task automatic t_ovf();
      logic [7:0] d;
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h0E);
      rd(2'd3, d); chk("R12 counter load", d, 8'h0E);
      wr(2'd0, 8'h02);
      rd(2'd1, d); chk("R7 no flag at 15", d, 8'h0F);
      wr(2'd0, 8'h02);
      rd(2'd1, d); chk("R7 wrap sets flag", d, 8'h40);
      chk("R8 irq masked", ovf_irq, 0);
      wr(2'd0, 8'h40); chk("R8 enable while pending", ovf_irq, 1);
      wr(2'd1, 8'h40);
      rd(2'd1, d); chk("R7 write-one clear", d, 8'h00);
      chk("R8 irq drops", ovf_irq, 0);
   endtask

   task automatic t_start();
      logic [7:0] d;
      wr(2'd0, 8'h00);
      @(negedge clk); start_hit = 1'b1;
      @(negedge clk); start_hit = 1'b0;
      rd(2'd1, d); chk("R8 start flag", d, 8'h80);
      chk("R8 start masked", start_irq, 0);
      wr(2'd0, 8'h80); chk("R8 start enable while pending", start_irq, 1);
      wr(2'd1, 8'h80); chk("R8 start clear", start_irq, 0);
   endtask

   task automatic t_wire();
      wr(2'd0, 8'h00); chk("R9 mode 00", {dout_oe, sclk_oe}, 2'b00);
      wr(2'd0, 8'h10); chk("R9 mode 01", {dout_oe, sclk_oe}, 2'b10);
      wr(2'd0, 8'h20); chk("R9 mode 10", {dout_oe, sclk_oe}, 2'b11);
      wr(2'd0, 8'h30); chk("R9 mode 11", {dout_oe, sclk_oe}, 2'b11);
   endtask

   task automatic t_shift();
      logic [7:0] d;
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
      sdi = 1'b1; wr(2'd0, 8'h02);
      sdi = 1'b0; wr(2'd0, 8'h02);
      sdi = 1'b1; wr(2'd0, 8'h02);
      rd(2'd2, d); chk("R11 shift order", d, 8'h05);
      chk("R11 sdo low", sdo, 0);
      wr(2'd2, 8'h80); chk("R11 sdo top bit", sdo, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_soft();
      t_timer();
      t_pin();
      t_ovf();
      t_start();
      t_wire();
      t_shift();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule